// File: doc/BRIEF.md
# Saturating Fixed-Point Add/Subtract Unit

This block adds or subtracts two signed fixed-point operands held in 32-bit registers. The operands are read either as one signed 32-bit word (Q31) or as two independent signed 16-bit halfwords packed into the word (Q15 pairs). In each lane, the result either wraps modulo the lane width or clamps to the nearest representable limit. The sum or difference is registered and appears one cycle after a valid input.

Any lane overflow sets a sticky flag at bit 20 of a 32-bit control register. This happens whether the lane wraps or saturates. Software reads the register through a read port. A write strobe loads the full register, which is how the flag is cleared. Overflow is judged differently for addition and for subtraction: a subtraction is never rewritten as the addition of a negated operand. This keeps the most negative subtrahend handled correctly.

Top module: `sat_addsub_unit`

## Requirements
- R1: One cycle after a clock edge that samples `in_valid` high, `out_valid` is 1 and `result` holds the outcome. After an edge that samples `in_valid` low, `out_valid` is 0 and `result` keeps its previous value.
- R2: The operation select is encoded as follows. `op_sub` = 1 subtracts `b_in` from `a_in` and `op_sub` = 0 adds them. `op_sat` = 1 saturates and `op_sat` = 0 wraps. `op_pair` = 1 selects two halfword lanes, with lane 0 in bits 15:0 and lane 1 in bits 31:16. `op_pair` = 0 selects one 32-bit lane. In wrap mode each lane equals a+b or a-b modulo 2^width.
- R3: An addition overflows a lane when both operands have the same sign and the raw sum's sign differs from that sign.
- R4: A subtraction overflows a lane when the operand signs differ and the raw difference's sign differs from the minuend's sign. For example, 0x80000000 - 0x80000000 gives 0 with no overflow, and 0x00000000 - 0x80000000 overflows.
- R5: When a saturating subtraction overflows, the lane becomes its positive limit (0x7FFF or 0x7FFFFFFF) if the minuend is zero or positive. Otherwise it becomes its negative limit (0x8000 or 0x80000000).
- R6: When a saturating addition overflows, the lane becomes its positive limit if `a` is greater than zero. Otherwise it becomes its negative limit.
- R7: In halfword-pair mode the two lanes are computed with no carry or borrow between bit 15 and bit 16. The flag is set if either lane overflows.
- R8: A lane overflow on a valid input sets bit 20 of the control register, in both wrap and saturate modes. The bit then stays set until a write changes it. Without a write or an overflow, the register holds its value.
- R9: A high `ctl_wr_en` loads all 32 bits of `ctl_wr_data` into the control register. If an overflow occurs in the same cycle, bit 20 of the loaded value is forced to 1.
- R10: Reset clears `out_valid`, `result` and the control register to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and operation select are valid |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| op_sat | input | 1 | 1 = saturate, 0 = wrap |
| op_pair | input | 1 | 1 = two 16-bit lanes, 0 = one 32-bit lane |
| a_in | input | 32 | First operand (minuend for subtraction) |
| b_in | input | 32 | Second operand (subtrahend for subtraction) |
| out_valid | output | 1 | Result register holds a fresh value |
| result | output | 32 | Registered sum or difference |
| ctl_wr_en | input | 1 | Load the control register |
| ctl_wr_data | input | 32 | Value to load into the control register |
| ctl_rd_data | output | 32 | Current control register contents |

## Verification
Directed cases come first. Subtracting the most negative word from zero and from itself shows whether subtraction overflow is judged on its own terms or through a negated operand. A zero minuend shows whether the saturation direction tests "zero or positive" or "strictly positive". Halfword pairs where one lane carries out of bit 15 show whether carries leak between lanes. Pairs where only one lane overflows show whether the flag merges both lanes.

Random operands come next. They are biased toward the lane limits, 0 and -1, across all eight operation selects, with periodic clears of the control register. Each result is compared against a bench model that computes exact wide arithmetic and range checks. A write issued together with an overflowing operation shows which of the two wins at bit 20.

// File: rtl/satalu_pkg.sv
package satalu_pkg;

    // Operation select carried from the ports into the lane array.
    typedef struct packed {
        logic sub;   // 1: a - b, 0: a + b
        logic sat;   // 1: clamp on overflow, 0: wrap
        logic pair;  // 1: two halfword lanes, 0: one word lane
    } op_t;

endpackage

// File: rtl/sat_lane.sv
module sat_lane #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         sat,
    output logic [W-1:0] res,
    output logic         ovf
);

    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] raw;
    logic         a_nonneg;
    logic         a_pos;
    logic         go_pos;

    always_comb begin
        raw      = sub ? (a - b) : (a + b);
        // Separate sign rules: the difference is never treated as a + (-b).
        if (sub) begin
            ovf = (a[W-1] ^ b[W-1]) & (a[W-1] ^ raw[W-1]);
        end else begin
            ovf = ~(a[W-1] ^ b[W-1]) & (a[W-1] ^ raw[W-1]);
        end
        a_nonneg = ~a[W-1];
        a_pos    = a_nonneg & (|a);
        go_pos   = sub ? a_nonneg : a_pos;
        if (ovf && sat) begin
            res = go_pos ? POS_LIM : NEG_LIM;
        end else begin
            res = raw;
        end
    end

endmodule

// File: rtl/lane_array.sv
module lane_array
    import satalu_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int HALF_W = 16
) (
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  op_t               op,
    output logic [WORD_W-1:0] res,
    output logic              any_ovf
);

    localparam int NUM_HALF = WORD_W / HALF_W;

    logic [WORD_W-1:0]   word_res;
    logic                word_ovf;
    logic [WORD_W-1:0]   half_res;
    logic [NUM_HALF-1:0] half_ovf;

    sat_lane #(.W(WORD_W)) u_word (
        .a   (a),
        .b   (b),
        .sub (op.sub),
        .sat (op.sat),
        .res (word_res),
        .ovf (word_ovf)
    );

    for (genvar i = 0; i < NUM_HALF; i++) begin : g_half
        sat_lane #(.W(HALF_W)) u_half (
            .a   (a[i*HALF_W +: HALF_W]),
            .b   (b[i*HALF_W +: HALF_W]),
            .sub (op.sub),
            .sat (op.sat),
            .res (half_res[i*HALF_W +: HALF_W]),
            .ovf (half_ovf[i])
        );
    end

    always_comb begin
        if (op.pair) begin
            res     = half_res;
            any_ovf = |half_ovf;
        end else begin
            res     = word_res;
            any_ovf = word_ovf;
        end
    end

endmodule

// File: rtl/ctl_flag_reg.sv
module ctl_flag_reg #(
    parameter int CTL_W    = 32,
    parameter int FLAG_POS = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             set_flag,
    output logic [CTL_W-1:0] ctl
);

    logic [CTL_W-1:0] ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d = wr_data;
        end
        if (set_flag) begin
            ctl_d[FLAG_POS] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl = ctl_q;

    // R8: flag survives any cycle without a write
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[FLAG_POS] && !wr_en |=> ctl_q[FLAG_POS]);

    // R8: nothing changes without a write or an overflow
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && !set_flag |=> $stable(ctl_q));

    // R9: an overflow wins over a simultaneous write at the flag bit
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_flag |=> ctl_q[FLAG_POS]);

    // R9: a plain write loads every bit
    a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !set_flag |=> ctl_q == $past(wr_data));

endmodule

// File: rtl/sat_addsub_unit.sv
module sat_addsub_unit
    import satalu_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int HALF_W   = 16,
    parameter int CTL_W    = 32,
    parameter int FLAG_POS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              op_sub,
    input  logic              op_sat,
    input  logic              op_pair,
    input  logic [WORD_W-1:0] a_in,
    input  logic [WORD_W-1:0] b_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    input  logic              ctl_wr_en,
    input  logic [CTL_W-1:0]  ctl_wr_data,
    output logic [CTL_W-1:0]  ctl_rd_data
);

    localparam logic [WORD_W-1:0] POS_LIM = {1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] NEG_LIM = {1'b1, {(WORD_W-1){1'b0}}};

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] res;
    } out_state_t;

    op_t               op_sel;
    logic [WORD_W-1:0] lane_res;
    logic              lane_ovf;
    out_state_t        st_d, st_q;

    assign op_sel = '{sub: op_sub, sat: op_sat, pair: op_pair};

    lane_array #(
        .WORD_W (WORD_W),
        .HALF_W (HALF_W)
    ) u_lanes (
        .a       (a_in),
        .b       (b_in),
        .op      (op_sel),
        .res     (lane_res),
        .any_ovf (lane_ovf)
    );

    ctl_flag_reg #(
        .CTL_W    (CTL_W),
        .FLAG_POS (FLAG_POS)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctl_wr_en),
        .wr_data  (ctl_wr_data),
        .set_flag (in_valid & lane_ovf),
        .ctl      (ctl_rd_data)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.res = lane_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.res;

    // R1: one-cycle latency of the valid strobe
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1: result is held when no operation is presented
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(result));

    // R5 and R6: a saturated word is a limit carrying the sign of a
    a_r6_sat_limit: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_sat && !op_pair && lane_ovf |=>
            (result == POS_LIM || result == NEG_LIM) &&
            result[WORD_W-1] == $past(a_in[WORD_W-1]));

endmodule

// File: tb/sim_sat_addsub_unit.sv
`timescale 1ns/1ps
module sim_sat_addsub_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, op_sub, op_sat, op_pair;
    logic [31:0] a_in, b_in;
    logic        out_valid;
    logic [31:0] result;
    logic        ctl_wr_en;
    logic [31:0] ctl_wr_data;
    logic [31:0] ctl_rd_data;

    int          errors = 0;
    int          checks = 0;
    bit          done   = 1'b0;
    logic [31:0] ctl_m  = '0;

    always #2 clk = ~clk;

    sat_addsub_unit u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .op_sub      (op_sub),
        .op_sat      (op_sat),
        .op_pair     (op_pair),
        .a_in        (a_in),
        .b_in        (b_in),
        .out_valid   (out_valid),
        .result      (result),
        .ctl_wr_en   (ctl_wr_en),
        .ctl_wr_data (ctl_wr_data),
        .ctl_rd_data (ctl_rd_data)
    );

    // Exact wide arithmetic with a range test per lane: {overflow, result}.
    function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic sub, input logic sat, input logic pair);
        int          w  = pair ? 16 : 32;
        int          nl = pair ? 2 : 1;
        logic [31:0] res = '0;
        logic        ovf = 1'b0;
        for (int l = 0; l < nl; l++) begin
            longint sa, sb, r, mx, mn;
            if (pair) begin
                sa = longint'($signed(a[l*16 +: 16]));
                sb = longint'($signed(b[l*16 +: 16]));
            end else begin
                sa = longint'($signed(a));
                sb = longint'($signed(b));
            end
            mx = (longint'(1) << (w - 1)) - 1;
            mn = -(longint'(1) << (w - 1));
            r  = sub ? (sa - sb) : (sa + sb);
            if (r > mx || r < mn) begin
                ovf = 1'b1;
                if (sat) r = (r > mx) ? mx : mn;
            end
            if (pair) res[l*16 +: 16] = r[15:0];
            else      res = r[31:0];
        end
        return {ovf, res};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one operation (optionally with a control write) and check one cycle later.
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic sub,
                          input logic sat, input logic pair, input bit wr,
                          input logic [31:0] wdata, input string tag);
        logic [32:0] m;
        a_in = a; b_in = b; op_sub = sub; op_sat = sat; op_pair = pair;
        in_valid = 1'b1;
        ctl_wr_en = wr; ctl_wr_data = wdata;
        @(negedge clk);
        in_valid = 1'b0; ctl_wr_en = 1'b0;
        m = model(a, b, sub, sat, pair);
        if (wr) ctl_m = wdata;
        if (m[32]) ctl_m[20] = 1'b1;
        chk({tag, " result"}, result, m[31:0]);
        chk({tag, " ctl"}, ctl_rd_data, ctl_m);
        chk({tag, " out_valid"}, {31'd0, out_valid}, 32'd1);
    endtask

    task automatic wr_ctl(input logic [31:0] d, input string tag);
        ctl_wr_en = 1'b1; ctl_wr_data = d;
        @(negedge clk);
        ctl_wr_en = 1'b0;
        ctl_m = d;
        chk(tag, ctl_rd_data, ctl_m);
    endtask

    function automatic logic [31:0] pick();
        logic [31:0] c;
        case ($urandom % 8)
            0: c = 32'h7FFF_FFFF;
            1: c = 32'h8000_0000;
            2: c = 32'h0000_0000;
            3: c = 32'hFFFF_FFFF;
            4: c = {($urandom % 2 == 0) ? 16'h7FFF : 16'h8000,
                    ($urandom % 2 == 0) ? 16'h8000 : 16'h7FFF};
            default: c = $urandom;
        endcase
        return c;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20240613));
        rst_n = 1'b0; in_valid = 1'b0; op_sub = 1'b0; op_sat = 1'b0; op_pair = 1'b0;
        a_in = '0; b_in = '0; ctl_wr_en = 1'b0; ctl_wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 out_valid", {31'd0, out_valid}, 32'd0);
        chk("R10 result", result, 32'd0);
        chk("R10 ctl", ctl_rd_data, 32'd0);

        // R4 and R5: subtraction corner cases
        run_op(32'h0000_0000, 32'h8000_0000, 1, 1, 0, 0, 0, "R5 zero minus most-negative");
        wr_ctl(32'h0, "R9 clear");
        run_op(32'h8000_0000, 32'h8000_0000, 1, 1, 0, 0, 0, "R4 min minus min");
        run_op(32'h0006_6666, 32'h0005_5555, 1, 1, 0, 0, 0, "R2 plain word sub");
        run_op(32'h8000_0000, 32'h0000_0001, 1, 1, 0, 0, 0, "R5 negative clamp");
        wr_ctl(32'h0, "R9 clear");
        // R7: paired halfword saturation on both lanes
        run_op(32'h1234_0000, 32'h8765_8000, 1, 1, 1, 0, 0, "R7 pair sub both lanes");
        wr_ctl(32'h0, "R9 clear");
        // R6 and R3: addition
        run_op(32'h7FFF_FFFF, 32'h0000_0001, 0, 1, 0, 0, 0, "R6 positive clamp");
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 0, 1, 0, 0, 0, "R6 negative clamp");
        wr_ctl(32'h0, "R9 clear");
        run_op(32'h0000_0000, 32'h8000_0000, 0, 1, 0, 0, 0, "R3 zero plus min no ovf");
        // R8: wrapping overflow also sets the flag
        run_op(32'h7FFF_FFFF, 32'h0000_0001, 0, 0, 0, 0, 0, "R8 wrap add sets flag");
        run_op(32'h0000_0001, 32'h0000_0001, 0, 0, 0, 0, 0, "R8 flag sticky");
        wr_ctl(32'h0, "R9 clear");
        // R7: no carry between lanes, one-lane overflow
        run_op(32'h0000_FFFF, 32'h0000_0001, 0, 0, 1, 0, 0, "R7 no cross-lane carry");
        run_op(32'h0000_7FFF, 32'h0000_0001, 0, 1, 1, 0, 0, "R7 low-lane overflow");
        wr_ctl(32'h0, "R9 clear");
        run_op(32'h8000_0000, 32'h0001_0000, 1, 0, 1, 0, 0, "R7 high-lane wrap sub");
        // R9: full load, and overflow wins over a same-cycle write
        wr_ctl(32'hA5A5_A5A5, "R9 full load");
        run_op(32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 1, 0, 1, 32'h0, "R9 overflow beats clear");
        run_op(32'h0000_0002, 32'h0000_0001, 1, 0, 0, 1, 32'h0000_0F0F, "R9 write without ovf");
        wr_ctl(32'h0, "R9 clear");

        // R1: hold when no valid input
        held = result;
        a_in = 32'h7FFF_FFFF; b_in = 32'hFFFF_FFFF; op_sub = 1'b1; op_sat = 1'b0;
        @(negedge clk);
        chk("R1 hold result", result, held);
        chk("R1 out_valid low", {31'd0, out_valid}, 32'd0);
        chk("R8 no flag without valid", ctl_rd_data, ctl_m);

        // Random mix across all operation selects
        for (int i = 0; i < 800; i++) begin
            logic [2:0] sel;
            sel = 3'($urandom);
            if (i % 60 == 59) wr_ctl(32'h0, "R9 periodic clear");
            run_op(pick(), pick(), sel[0], sel[1], sel[2], 0, 0, "R2 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule